// File: doc/BRIEF.md
# Command-Sequenced I2C Byte Master

This block is an I2C bus master that software drives one bus phase at a time. A single command word asks for one of four actions: a start condition, one byte sent, one byte received, or a stop condition. The block then plays that phase out on the two open-drain lines and reports that it is idle again. Software builds a complete transaction by issuing these phases in order. If a start is requested while the clock line is held low after a byte, the block produces a repeated start without any extra command.

Each line is driven through an output-enable that pulls it low when set. The data line is read back through its own input. A configuration register holds a divider. The half-period of the bus clock is the divider multiplied by a fixed parameter `MULT` system cycles, with a floor of one cycle. The half-period is latched when each command is accepted. A status read returns the idle flag, the acknowledge seen after the last sent byte, and the last received byte.

Top module: `cmd_i2c_master`

## Requirements
- R1: After reset the block is idle and releases both lines (`scl_oe`=0, `sda_oe`=0). The status word reads 0x200: idle in bit 9, acknowledge in bit 8 clear, received byte in bits 7:0 equal to zero.
- R2: A write with `reg_addr`=1 stores the low `DIV_W` bits of `reg_wdata` as the divider, and a read at that address returns them zero-extended. The half-period is H = max(1, divider*MULT) cycles. A divider written while a command runs applies from the next accepted command.
- R3: A write with `reg_addr`=0 is a command word laid out as: data in bits 7:0, ack flag in bit 8, send in bit 9, receive in bit 10, start in bit 11, stop in bit 12. When several action bits are set, one action runs, chosen in the order start, stop, send, receive. A word with none of bits 12:9 set leaves the block idle and the lines unchanged.
- R4: Start takes 3 half-periods. It releases SDA, then releases SCL, then pulls SDA low while SCL is high. It ends with SCL released and SDA low. Issued after a byte, this forms a repeated start.
- R5: Stop takes 4 half-periods. It pulls SCL low, then pulls SDA low, then releases SCL, then releases SDA while SCL is high. Both lines end released.
- R6: Send takes 28 half-periods. It clocks out the 8 data bits MSB first, then a ninth clock with SDA released. Each bit slot is SCL low for two half-periods and high for one. The acknowledge status becomes 1 exactly when SDA is low at the end of the ninth high phase. The command ends with SCL low.
- R7: Receive takes 28 half-periods. It releases SDA for 8 clocks and samples each bit at the end of the high phase, MSB first. On the ninth clock it pulls SDA low if the ack flag is set and releases it otherwise. The received byte updates when the command ends. The acknowledge status is left unchanged.
- R8: Status bit 9 reads 0 from the cycle after a command is accepted for exactly N*H cycles, with N = 3, 4 or 28 per R4 to R7, and then reads 1.
- R9: Command words written while the block is busy are ignored. The running command keeps its data, timing and length.
- R10: The received byte holds its value through start, stop and send commands until the next receive completes.
- R11: During a send or receive, SDA changes only while SCL is low. Only start and stop change SDA while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 1 | Register select: 0 command/status, 1 divider |
| reg_wdata | input | 13 | Write data |
| reg_rdata | output | 13 | Read data of the selected register (combinational) |
| scl_oe | output | 1 | Pulls the clock line low when 1 |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| sda_in | input | 1 | Sensed level of the data line |

## Verification
The assertions assume that the clock line is never held low by another device, since the sequencer counts half-periods without looking back at SCL. They also assume that `sda_in` is settled at each sampling edge. The bench's target model meets both assumptions. It wires SDA as the AND of both drivers and changes its own bit only on falling system edges while SCL is low, so every sample the master takes at the end of a high phase sees a stable level. Register writes are single-cycle pulses driven away from the active edge. The one deliberate overlap is a command and a divider write issued while a transfer is running.

// File: rtl/cmdi2c_pkg.sv
package cmdi2c_pkg;
  localparam int BYTE_W     = 8;
  localparam int B_ACK      = 8;
  localparam int B_SEND     = 9;
  localparam int B_RECV     = 10;
  localparam int B_START    = 11;
  localparam int B_STOP     = 12;
  localparam int B_IDLE     = 9;
  localparam int REG_W      = B_STOP + 1;
  localparam int XFER_STEPS = 3 * (BYTE_W + 1) + 1;
  localparam int STEP_W     = $clog2(XFER_STEPS);

  typedef enum logic [1:0] {OP_NONE, OP_START, OP_STOP, OP_XFER} op_e;

  // half-period in system cycles, never below one
  function automatic int unsigned half_period(int unsigned div, int unsigned mult);
    int unsigned p;
    p = div * mult;
    return (p == 0) ? 1 : p;
  endfunction

  function automatic logic [STEP_W-1:0] final_step(op_e op);
    case (op)
      OP_START: return STEP_W'(2);
      OP_STOP:  return STEP_W'(3);
      OP_XFER:  return STEP_W'(XFER_STEPS - 1);
      default:  return '0;
    endcase
  endfunction

  function automatic logic [1:0] slot_phase(logic [STEP_W-1:0] s);
    return 2'(int'(s) % 3);
  endfunction

  function automatic logic [3:0] slot_bit(logic [STEP_W-1:0] s);
    return 4'(int'(s) / 3);
  endfunction

  // line levels {scl_rel, sda_rel} on entry to a step
  function automatic logic [1:0] step_drive(op_e op, logic [STEP_W-1:0] s,
                                            logic [BYTE_W:0] pat, logic scl, logic sda);
    logic [1:0]      r;
    logic [BYTE_W:0] sh;
    r  = {scl, sda};
    sh = pat << slot_bit(s);
    case (op)
      OP_START: begin
        if (s == 0)      r[0] = 1'b1;
        else if (s == 1) r[1] = 1'b1;
        else             r[0] = 1'b0;
      end
      OP_STOP: begin
        if (s == 0)      r[1] = 1'b0;
        else if (s == 1) r[0] = 1'b0;
        else if (s == 2) r[1] = 1'b1;
        else             r[0] = 1'b1;
      end
      OP_XFER: begin
        if (int'(s) == XFER_STEPS - 1) r[1] = 1'b0;
        else begin
          case (slot_phase(s))
            2'd0:    r[1] = 1'b0;
            2'd1:    r[0] = sh[BYTE_W];
            default: r[1] = 1'b1;
          endcase
        end
      end
      default: r = {scl, sda};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cmdi2c_timer.sv
module cmdi2c_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tmr_q <= '0;
    else if (load)                 tmr_q <= load_val;
    else if (run && tmr_q != '0)   tmr_q <= tmr_q - 1'b1;
  end

  assign expire = run && (tmr_q == '0);

  a_r8_reload_exact: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> tmr_q == $past(load_val));
endmodule

// File: rtl/cmdi2c_regs.sv
module cmdi2c_regs import cmdi2c_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                idle,
  input  logic                ack_st,
  input  logic [BYTE_W-1:0]   rx_byte,
  output logic [DIV_W-1:0]    div_q,
  output logic                cmd_hit,
  output logic                cmd_go,
  output op_e                 cmd_op,
  output logic                cmd_rd,
  output logic [BYTE_W:0]     cmd_pat
);
  assign cmd_hit = reg_wr && !reg_addr;

  always_comb begin
    cmd_op = OP_NONE;
    if (reg_wdata[B_START])                         cmd_op = OP_START;
    else if (reg_wdata[B_STOP])                     cmd_op = OP_STOP;
    else if (reg_wdata[B_SEND] || reg_wdata[B_RECV]) cmd_op = OP_XFER;
  end

  assign cmd_rd  = !reg_wdata[B_SEND];
  assign cmd_pat = reg_wdata[B_SEND] ? {reg_wdata[BYTE_W-1:0], 1'b1}
                                     : {{BYTE_W{1'b1}}, !reg_wdata[B_ACK]};
  assign cmd_go  = cmd_hit && idle && (cmd_op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 div_q <= '0;
    else if (reg_wr && reg_addr) div_q <= reg_wdata[DIV_W-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) reg_rdata = REG_W'(div_q);
    else begin
      reg_rdata[BYTE_W-1:0] = rx_byte;
      reg_rdata[B_ACK]      = ack_st;
      reg_rdata[B_IDLE]     = idle;
    end
  end

  a_r2_cfg_store: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr) |=> div_q == $past(reg_wdata[DIV_W-1:0]));
endmodule

// File: rtl/cmdi2c_seq.sv
module cmdi2c_seq import cmdi2c_pkg::*; #(
  parameter int HP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_hit,
  input  logic              cmd_go,
  input  op_e               cmd_op,
  input  logic              cmd_rd,
  input  logic [BYTE_W:0]   cmd_pat,
  input  logic [HP_W-1:0]   hp_in,
  input  logic              expire,
  input  logic              sda_in,
  output logic              tmr_load,
  output logic [HP_W-1:0]   tmr_val,
  output logic              idle,
  output logic              scl_rel,
  output logic              sda_rel,
  output logic              ack_q,
  output logic [BYTE_W-1:0] rx_q
);
  op_e               op_q;
  logic [STEP_W-1:0] step_q;
  logic [BYTE_W:0]   pat_q;
  logic              rd_q;
  logic [HP_W-1:0]   hp_q;
  logic [BYTE_W-1:0] shift_q;

  // named events used by the datapath and the assertions
  logic step_end, is_last, finish, advance, sample_ev, ack_upd_ev, rx_load;
  logic [STEP_W-1:0] step_nx;

  assign idle       = (op_q == OP_NONE);
  assign is_last    = (step_q == final_step(op_q));
  assign step_end   = !idle && expire;
  assign finish     = step_end && is_last;
  assign advance    = step_end && !is_last;
  assign step_nx    = step_q + 1'b1;
  assign sample_ev  = step_end && (op_q == OP_XFER) && !is_last && (slot_phase(step_q) == 2'd2);
  assign ack_upd_ev = sample_ev && (slot_bit(step_q) == 4'(BYTE_W)) && !rd_q;
  assign rx_load    = finish && (op_q == OP_XFER) && rd_q;

  assign tmr_load = cmd_go || advance;
  assign tmr_val  = cmd_go ? hp_in - 1'b1 : hp_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_NONE;
      step_q  <= '0;
      pat_q   <= '1;
      rd_q    <= 1'b0;
      hp_q    <= HP_W'(1);
      scl_rel <= 1'b1;
      sda_rel <= 1'b1;
      shift_q <= '0;
      ack_q   <= 1'b0;
      rx_q    <= '0;
    end else begin
      if (cmd_go) begin
        op_q   <= cmd_op;
        step_q <= '0;
        pat_q  <= cmd_pat;
        rd_q   <= cmd_rd;
        hp_q   <= hp_in;
        {scl_rel, sda_rel} <= step_drive(cmd_op, '0, cmd_pat, scl_rel, sda_rel);
      end else if (advance) begin
        step_q <= step_nx;
        {scl_rel, sda_rel} <= step_drive(op_q, step_nx, pat_q, scl_rel, sda_rel);
      end else if (finish) begin
        op_q <= OP_NONE;
      end
      if (sample_ev && slot_bit(step_q) != 4'(BYTE_W)) shift_q <= {shift_q[BYTE_W-2:0], sda_in};
      if (ack_upd_ev) ack_q <= !sda_in;
      if (rx_load)    rx_q  <= shift_q;
    end
  end

  a_r11_sda_steady_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_XFER && scl_rel && $past(scl_rel)) |-> sda_rel == $past(sda_rel));
  a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> idle);
  a_r6_xfer_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && op_q == OP_XFER) |=> !scl_rel);
  a_r4_start_end_state: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && op_q == OP_START) |=> scl_rel && !sda_rel);
  a_r5_stop_end_state: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && op_q == OP_STOP) |=> scl_rel && sda_rel);
  a_r6_ack_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ack_upd_ev |=> ack_q == !$past(sda_in));
  a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_load |=> $stable(rx_q));
  a_r9_busy_ignores_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && !idle) |=> $stable(pat_q) && $stable(hp_q) && $stable(rd_q));
endmodule

// File: rtl/cmd_i2c_master.sv
module cmd_i2c_master import cmdi2c_pkg::*; #(
  parameter int DIV_W = 8,
  parameter int MULT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  localparam int HP_MAX = ((1 << DIV_W) - 1) * MULT;
  localparam int HP_W   = $clog2(HP_MAX + 1);

  logic              idle, ack_st, cmd_hit, cmd_go, cmd_rd;
  logic              tmr_load, expire, scl_rel, sda_rel;
  logic [BYTE_W-1:0] rx_byte;
  logic [DIV_W-1:0]  div_q;
  logic [BYTE_W:0]   cmd_pat;
  logic [HP_W-1:0]   hp_in, tmr_val;
  op_e               cmd_op;

  assign hp_in  = HP_W'(half_period(int'(div_q), MULT));
  assign scl_oe = !scl_rel;
  assign sda_oe = !sda_rel;

  cmdi2c_regs #(.DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .idle(idle),
    .ack_st(ack_st), .rx_byte(rx_byte), .div_q(div_q), .cmd_hit(cmd_hit),
    .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_rd(cmd_rd), .cmd_pat(cmd_pat)
  );

  cmdi2c_timer #(.CNT_W(HP_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(!idle),
    .load_val(tmr_val), .expire(expire)
  );

  cmdi2c_seq #(.HP_W(HP_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .cmd_hit(cmd_hit), .cmd_go(cmd_go),
    .cmd_op(cmd_op), .cmd_rd(cmd_rd), .cmd_pat(cmd_pat), .hp_in(hp_in),
    .expire(expire), .sda_in(sda_in), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .idle(idle), .scl_rel(scl_rel), .sda_rel(sda_rel), .ack_q(ack_st),
    .rx_q(rx_byte)
  );

  a_r1_idle_releases: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !scl_oe || $past(scl_oe));
endmodule

// File: tb/cmd_i2c_master_tb.sv
module cmd_i2c_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;
  localparam int MULT  = 2;
  localparam logic [12:0] C_ACK = 13'h100, C_WR = 13'h200, C_RD = 13'h400,
                          C_ST = 13'h800, C_SP = 13'h1000;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [12:0] reg_wdata = '0;
  logic [12:0] reg_rdata;
  logic scl_oe, sda_oe;
  logic slave_sda = 1'b1;
  logic sda_in;
  assign sda_in = !sda_oe && slave_sda;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_i2c_master #(.DIV_W(DIV_W), .MULT(MULT)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda_in)
  );

  int n_chk = 0, n_bad = 0;

  // bus monitor and target model
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  int rise_cnt = 0, start_cnt = 0, stop_cnt = 0, base = 0;
  logic [8:0] cap = '0;
  logic [8:0] spat = '1;

  always @(negedge clk) begin
    logic scl_l, sda_l;
    int idx;
    scl_l = !scl_oe;
    sda_l = sda_in;
    if (!prev_scl && scl_l) begin
      cap <= {cap[7:0], sda_l};
      rise_cnt <= rise_cnt + 1;
    end
    if (prev_scl && scl_l && prev_sda && !sda_l) start_cnt <= start_cnt + 1;
    if (prev_scl && scl_l && !prev_sda && sda_l) stop_cnt <= stop_cnt + 1;
    idx = rise_cnt - base;
    if (!scl_l) slave_sda <= (idx >= 0 && idx < 9) ? spat[8-idx] : 1'b1;
    prev_scl <= scl_l;
    prev_sda <= sda_l;
  end

  function automatic int hp(int d);
    int h;
    h = d * MULT;
    return (h < 1) ? 1 : h;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [12:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic arm(logic [8:0] p);
    base = rise_cnt;
    spat = p;
  endtask

  task automatic run(logic [12:0] cmd, output int cnt);
    wr(1'b0, cmd);
    cnt = 0;
    while (!reg_rdata[9] && cnt < 100000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic set_div(int d);
    wr(1'b1, 13'(d));
    reg_addr = 1'b1; #1;
    chk(reg_rdata == 13'(d), "R2 divider readback", int'(reg_rdata), d);
    reg_addr = 1'b0; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int c, h, s0, p0;
    logic exp_ack;
    logic [7:0] exp_rx, v, sv;
    bit sack, aflag;
    exp_ack = 1'b0; exp_rx = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_rdata == 13'h200, "R1 status after reset", int'(reg_rdata), 'h200);
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);

    for (int d = 0; d < 4; d++) begin
      h = hp(d);
      set_div(d);
      s0 = start_cnt;
      run(C_ST, c);
      chk(c == 3*h, "R8 start length", c, 3*h);
      chk(start_cnt == s0 + 1, "R4 start condition seen", start_cnt - s0, 1);
      chk(!scl_oe && sda_oe, "R4 start end state", {scl_oe, sda_oe}, 1);

      v = 8'(8'h5A + d * 8'h3B);
      sack = (d % 2 == 0);
      arm({8'hFF, !sack});
      s0 = start_cnt; p0 = stop_cnt;
      run(C_WR | 13'(v), c);
      exp_ack = sack;
      chk(c == 28*h, "R8 send length", c, 28*h);
      chk(cap[8:1] == v, "R6 sent bits", cap[8:1], v);
      chk(reg_rdata[8] == exp_ack, "R6 ack status", reg_rdata[8], exp_ack);
      chk(scl_oe, "R6 ends with SCL low", scl_oe, 1);
      chk(reg_rdata[7:0] == exp_rx, "R10 rx kept over send", reg_rdata[7:0], exp_rx);
      chk(start_cnt == s0 && stop_cnt == p0, "R11 no SDA edge under high SCL in send",
          start_cnt - s0 + stop_cnt - p0, 0);

      sv = 8'(8'hC3 ^ (d * 8'h11));
      aflag = (d >= 2);
      arm({sv, 1'b1});
      s0 = start_cnt; p0 = stop_cnt;
      run(C_RD | (aflag ? C_ACK : 13'h0), c);
      exp_rx = sv;
      chk(c == 28*h, "R8 receive length", c, 28*h);
      chk(reg_rdata[7:0] == sv, "R7 received byte", reg_rdata[7:0], sv);
      chk(cap[0] == !aflag, "R7 ninth bit driven", cap[0], !aflag);
      chk(reg_rdata[8] == exp_ack, "R7 ack status untouched", reg_rdata[8], exp_ack);
      chk(start_cnt == s0 && stop_cnt == p0, "R11 no SDA edge under high SCL in receive",
          start_cnt - s0 + stop_cnt - p0, 0);

      s0 = start_cnt;
      run(C_ST, c);
      chk(c == 3*h, "R4 repeated start length", c, 3*h);
      chk(start_cnt == s0 + 1, "R4 repeated start seen", start_cnt - s0, 1);
      chk(!scl_oe && sda_oe, "R4 repeated start end state", {scl_oe, sda_oe}, 1);
      chk(reg_rdata[7:0] == exp_rx, "R10 rx kept over start", reg_rdata[7:0], exp_rx);

      p0 = stop_cnt;
      run(C_SP, c);
      chk(c == 4*h, "R5 stop length", c, 4*h);
      chk(stop_cnt == p0 + 1, "R5 stop condition seen", stop_cnt - p0, 1);
      chk(!scl_oe && !sda_oe, "R5 lines released", {scl_oe, sda_oe}, 0);
      chk(reg_rdata[7:0] == exp_rx, "R10 rx kept over stop", reg_rdata[7:0], exp_rx);
    end

    // R3 decode and priority, divider 1
    set_div(1);
    h = hp(1);
    wr(1'b0, 13'h0AB);
    chk(reg_rdata[9] == 1'b1, "R3 flagless word ignored", reg_rdata[9], 1);
    chk(!scl_oe && !sda_oe, "R3 flagless word leaves lines", {scl_oe, sda_oe}, 0);
    run(C_ST | C_WR | 13'h55, c);
    chk(c == 3*h, "R3 start outranks send", c, 3*h);
    p0 = stop_cnt;
    run(C_SP | C_RD, c);
    chk(c == 4*h && stop_cnt == p0 + 1, "R3 stop outranks receive", c, 4*h);
    arm({8'hFF, 1'b0});
    run(C_ST | C_SP, c);
    chk(c == 3*h, "R3 start outranks stop", c, 3*h);
    arm(9'h1FF);
    run(C_WR | C_RD | 13'h3C, c);
    chk(c == 28*h && cap[8:1] == 8'h3C, "R3 send outranks receive", cap[8:1], 8'h3C);

    // R9: command and divider written during a send
    arm({8'hFF, 1'b0});
    p0 = stop_cnt;
    wr(1'b0, C_WR | 13'h96);
    c = 0;
    while (!(reg_rdata[9] && !reg_addr) && c < 100000) begin
      c++;
      if (c == 5) begin reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = C_SP; end
      else if (c == 6) begin reg_addr = 1'b1; reg_wdata = 13'd3; end
      else if (c == 7) begin reg_wr = 1'b0; reg_addr = 1'b0; end
      @(negedge clk);
    end
    chk(c == 28*h, "R9 length kept while busy", c, 28*h);
    chk(cap[8:1] == 8'h96, "R9 data kept while busy", cap[8:1], 8'h96);
    chk(stop_cnt == p0 && scl_oe, "R9 ignored stop had no effect", stop_cnt - p0, 0);
    run(C_SP, c);
    chk(c == 4*hp(3), "R2 divider applies at next command", c, 4*hp(3));

    // exhaustive byte sweep at the smallest half-period
    set_div(0);
    run(C_ST, c);
    for (int b = 0; b < 256; b++) begin
      sack = b[0];
      arm({8'hFF, !sack});
      run(C_WR | 13'(b), c);
      chk(cap[8:1] == 8'(b) && c == 28, "R6 send sweep", cap[8:1], b);
      chk(reg_rdata[8] == sack, "R6 ack sweep", reg_rdata[8], sack);
      exp_ack = sack;
    end
    for (int b = 0; b < 256; b++) begin
      aflag = b[1];
      arm({8'(b), 1'b1});
      run(C_RD | (aflag ? C_ACK : 13'h0), c);
      chk(reg_rdata[7:0] == 8'(b) && c == 28, "R7 receive sweep", reg_rdata[7:0], b);
      chk(cap[0] == !aflag && reg_rdata[8] == exp_ack, "R7 ack drive sweep", cap[0], !aflag);
    end
    run(C_SP, c);
    chk(!scl_oe && !sda_oe, "R5 final release", {scl_oe, sda_oe}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule